// File: doc/BRIEF.md
# 32-bit Barrel Shifter with Carry-Out

This block shifts or rotates one data word by an amount and produces the shifted word together with a shifter carry. The amount is a full byte and is never reduced modulo the word width. Counts of exactly the word width, and counts above it, therefore have their own defined results. A 3-bit code chooses between logical left, logical right, arithmetic right, rotate right, and rotate right by one through the carry. Codes outside that set pass the word and the carry through unchanged.

The block sits in front of an arithmetic unit. The amount can come from a register's low byte or from an immediate, and the incoming carry is the current carry flag. By default the results go through one register stage. A valid strobe travels with the data, so the consumer sees the result and carry one clock after it presents a request. The stage can be removed by parameter, which makes the path purely combinational.

Top module: `barrel_shift_unit`

## Requirements
- R1: For codes 0 (logical left), 1 (logical right), 2 (arithmetic right) and 3 (rotate right), an amount of 0 returns the operand unchanged and returns the carry-in as the carry-out.
- R2: Code 0, logical left. For amounts 1 to 31 the result is the operand shifted up, and the carry is the last bit pushed out of bit 31. An amount of 32 gives result 0 with carry equal to operand bit 0. Amounts from 33 to 255 give result 0 and carry 0.
- R3: Code 1, logical right. For amounts 1 to 31 the result is the operand shifted down with zero fill, and the carry is the last bit pushed out of bit 0. An amount of 32 gives result 0 with carry equal to operand bit 31. Amounts from 33 to 255 give result 0 and carry 0.
- R4: Code 2, arithmetic right. For amounts 1 to 31 the result is shifted down with sign fill, and the carry is the last bit pushed out of bit 0. Any amount of 32 or more fills every result bit with operand bit 31, and the carry also equals operand bit 31.
- R5: Code 3, rotate right. The rotation distance is the amount modulo 32, and the carry is bit 31 of the rotated result. When the amount is nonzero but a multiple of 32, the result equals the operand and the carry equals operand bit 31.
- R6: Code 4, rotate right by one through the carry. The result is {carry-in, operand[31:1]} and the carry-out is operand bit 0. The amount input has no effect.
- R7: Codes 5, 6 and 7 return the operand unchanged and the carry-in as the carry-out, for any amount.
- R8: With the register stage present (PIPE=1), the result, carry and out_valid reflect a request one clock edge after the edge that samples in_valid high. out_valid is low one edge after in_valid is sampled low.
- R9: While rst is high at a clock edge, out_valid, out_result and out_carry are cleared to 0 at that edge, even if in_valid is high.
- R10: When in_valid is sampled low, out_result and out_carry keep their previous values, whatever the operand, amount, code and carry inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 32 | Word to shift |
| in_amount | input | 8 | Shift amount, not masked |
| in_carry | input | 1 | Carry flag in |
| in_op | input | 3 | Operation code |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Shifter carry out |

## Verification
A misclassified amount appears at the ports on the first request that uses a boundary count. Counts 0, 32 and values above 32 would return a masked shift, or a carry taken from the wrong bit, in the cycle right after the request. A broken output register appears within one clock in either of two ways: out_valid fails to follow in_valid, or results change on idle cycles. The bench compares every code against a bit-serial model at counts 0, 1, 31, 32, 33 and 255, among others, so any such fault shows up on the next registered result.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_op_e;

  // Classification of the unmasked amount against the word width
  typedef struct packed {
    logic is_zero;   // amount == 0
    logic is_width;  // amount == word width
    logic beyond;    // amount > word width
    logic mod_zero;  // low log2(width) bits all zero
  } amt_class_t;

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
  import shift_pkg::*;
#(
  parameter int W   = 32,
  parameter int CW  = 8,
  localparam int SHW = $clog2(W)
) (
  input  logic [CW-1:0] amount,
  output amt_class_t    cls,
  output logic [SHW:0]  amt_sat,
  output logic [SHW-1:0] amt_mod
);

  localparam logic [CW-1:0] WIDTH_CNT = CW'(W);

  always_comb begin
    cls.is_zero  = (amount == '0);
    cls.is_width = (amount == WIDTH_CNT);
    cls.beyond   = (amount > WIDTH_CNT);
    cls.mod_zero = (amount[SHW-1:0] == '0);
    // Saturate to the width: every larger count acts like the width itself
    if (amount >= WIDTH_CNT) amt_sat = (SHW+1)'(W);
    else                     amt_sat = amount[SHW:0];
    amt_mod = amount[SHW-1:0];
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [2:0]     op,
  input  logic [W-1:0]   operand,
  input  logic           cin,
  input  amt_class_t     cls,
  input  logic [SHW:0]   amt_sat,
  input  logic [SHW-1:0] amt_mod,
  output logic [W-1:0]   res,
  output logic           cout
);

  // One guard bit beyond the word catches the last bit shifted out
  logic [W:0]          lsl_w;
  logic [W:0]          lsr_w;
  logic signed [W:0]   asr_w;
  logic [2*W-1:0]      ror_w;
  logic [W-1:0]        ror_r;
  shift_op_e           op_e;

  assign op_e  = shift_op_e'(op);
  assign lsl_w = {1'b0, operand} << amt_sat;
  assign lsr_w = {operand, 1'b0} >> amt_sat;
  assign asr_w = $signed({operand, 1'b0}) >>> amt_sat;
  assign ror_w = {operand, operand} >> amt_mod;
  assign ror_r = ror_w[W-1:0];

  always_comb begin
    res  = operand;
    cout = cin;
    case (op_e)
      SH_LSL: begin
        if (cls.is_zero) begin
          res = operand; cout = cin;
        end else if (cls.beyond) begin
          res = '0; cout = 1'b0;
        end else begin
          res = lsl_w[W-1:0]; cout = lsl_w[W];
        end
      end
      SH_LSR: begin
        if (cls.is_zero) begin
          res = operand; cout = cin;
        end else if (cls.beyond) begin
          res = '0; cout = 1'b0;
        end else begin
          res = lsr_w[W:1]; cout = lsr_w[0];
        end
      end
      SH_ASR: begin
        if (cls.is_zero) begin
          res = operand; cout = cin;
        end else begin
          res = asr_w[W:1]; cout = asr_w[0];
        end
      end
      SH_ROR: begin
        if (cls.is_zero) begin
          res = operand; cout = cin;
        end else begin
          res = ror_r; cout = ror_r[W-1];
        end
      end
      SH_RRX: begin
        res  = {cin, operand[W-1:1]};
        cout = operand[0];
      end
      default: begin
        res = operand; cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage #(
  parameter int W    = 32,
  parameter int PIPE = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vin,
  input  logic [W-1:0] res,
  input  logic         cout,
  output logic         vout,
  output logic [W-1:0] res_q,
  output logic         cout_q
);

  generate
    if (PIPE != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          vout   <= 1'b0;
          res_q  <= '0;
          cout_q <= 1'b0;
        end else begin
          vout <= vin;
          if (vin) begin
            res_q  <= res;
            cout_q <= cout;
          end
        end
      end
    end else begin : g_comb
      assign vout   = vin;
      assign res_q  = res;
      assign cout_q = cout;
    end
  endgenerate

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int W    = 32,
  parameter int CW   = 8,
  parameter int PIPE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_operand,
  input  logic [CW-1:0] in_amount,
  input  logic          in_carry,
  input  logic [2:0]    in_op,
  output logic          out_valid,
  output logic [W-1:0]  out_result,
  output logic          out_carry
);

  localparam int SHW = $clog2(W);

  amt_class_t     cls;
  logic [SHW:0]   amt_sat;
  logic [SHW-1:0] amt_mod;
  logic [W-1:0]   dp_res;
  logic           dp_cout;

  shift_amount_decode #(.W(W), .CW(CW)) u_dec (
    .amount  (in_amount),
    .cls     (cls),
    .amt_sat (amt_sat),
    .amt_mod (amt_mod)
  );

  shift_datapath #(.W(W)) u_dp (
    .op      (in_op),
    .operand (in_operand),
    .cin     (in_carry),
    .cls     (cls),
    .amt_sat (amt_sat),
    .amt_mod (amt_mod),
    .res     (dp_res),
    .cout    (dp_cout)
  );

  shift_out_stage #(.W(W), .PIPE(PIPE)) u_out (
    .clk    (clk),
    .rst    (rst),
    .vin    (in_valid),
    .res    (dp_res),
    .cout   (dp_cout),
    .vout   (out_valid),
    .res_q  (out_result),
    .cout_q (out_carry)
  );

endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk #(
  parameter int W    = 32,
  parameter int CW   = 8,
  parameter int PIPE = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  in_operand,
  input logic [CW-1:0] in_amount,
  input logic          in_carry,
  input logic [2:0]    in_op,
  input logic          out_valid,
  input logic [W-1:0]  out_result,
  input logic          out_carry
);

  generate
    if (PIPE != 0) begin : g_seq
      AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && !out_carry)); // R9

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8

      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8

      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_carry))); // R10

      AST_ZERO_PASSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amount == '0 && in_op <= 3'd3) |=>
          (out_result == $past(in_operand) && out_carry == $past(in_carry))); // R1

      AST_LSL_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0 && in_amount > CW'(W)) |=>
          (out_result == '0 && !out_carry)); // R2

      AST_LSR_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd1 && in_amount > CW'(W)) |=>
          (out_result == '0 && !out_carry)); // R3

      AST_RRX_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4) |=>
          (out_carry == $past(in_operand[0]) && out_result[W-1] == $past(in_carry))); // R6

      AST_SPARE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 3'd5) |=>
          (out_result == $past(in_operand) && out_carry == $past(in_carry))); // R7
    end
  endgenerate

endmodule

bind barrel_shift_unit barrel_shift_chk #(.W(W), .CW(CW), .PIPE(PIPE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_amount  (in_amount),
  .in_carry   (in_carry),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_carry  (out_carry)
);

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [7:0]  in_amount = '0;
  logic        in_carry = 1'b0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  barrel_shift_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_amount(in_amount), .in_carry(in_carry), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
  );

  // Bit-serial reference: one single-bit step per count
  function automatic logic [32:0] model(input logic [2:0] op, input logic [7:0] cnt,
                                        input logic [31:0] a, input logic c);
    logic [31:0] r;
    logic        k;
    r = a;
    k = c;
    case (op)
      3'd0: for (int i = 0; i < int'(cnt); i++) begin k = r[31]; r = {r[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < int'(cnt); i++) begin k = r[0]; r = {1'b0, r[31:1]}; end
      3'd2: for (int i = 0; i < int'(cnt); i++) begin k = r[0]; r = {r[31], r[31:1]}; end
      3'd3: for (int i = 0; i < int'(cnt); i++) begin k = r[0]; r = {r[0], r[31:1]}; end
      3'd4: begin k = a[0]; r = {c, a[31:1]}; end
      default: ;
    endcase
    return {k, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Present one request, then check the registered outputs after the next edge
  task automatic apply(input logic [2:0] op, input logic [7:0] cnt,
                       input logic [31:0] a, input logic c, input string req);
    logic [32:0] exp;
    exp = model(op, cnt, a, c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_amount = cnt; in_operand = a; in_carry = c;
    @(posedge clk); #1;
    check(out_valid === 1'b1, "R8", {32'd0, out_valid}, 33'd1);
    check({out_carry, out_result} === exp, req, {out_carry, out_result}, exp);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0 && out_result === '0 && out_carry === 1'b0, "R9",
          {out_carry, out_result}, 33'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep(input logic [2:0] op, input string tag);
    logic [31:0] pats [4];
    logic [7:0]  cnts [10];
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h4000_0000};
    cnts = '{8'd0, 8'd1, 8'd5, 8'd16, 8'd31, 8'd32, 8'd33, 8'd64, 8'd200, 8'd255};
    foreach (pats[p]) begin
      foreach (cnts[k]) begin
        for (int c = 0; c < 2; c++) begin
          apply(op, cnts[k], pats[p], c[0], (cnts[k] == 8'd0) ? "R1" : tag);
        end
      end
    end
  endtask

  task automatic t_rrx();
    // Amount has no effect: try several amounts including 0 and 32
    apply(3'd4, 8'd0,   32'h0000_0001, 1'b1, "R6");
    apply(3'd4, 8'd32,  32'h0000_0001, 1'b0, "R6");
    apply(3'd4, 8'd255, 32'hFFFF_FFFE, 1'b1, "R6");
    apply(3'd4, 8'd7,   32'h1234_5679, 1'b0, "R6");
  endtask

  task automatic t_spare();
    for (int op = 5; op < 8; op++) begin
      apply(op[2:0], 8'd0,  32'hDEAD_BEEF, 1'b1, "R7");
      apply(op[2:0], 8'd33, 32'h0F0F_1234, 1'b0, "R7");
    end
  endtask

  task automatic t_hold();
    logic [32:0] held;
    apply(3'd0, 8'd4, 32'h0000_00F1, 1'b0, "R2");
    held = {out_carry, out_result};
    @(negedge clk);
    in_valid = 1'b0; in_op = 3'd1; in_amount = 8'd3; in_operand = 32'hFFFF_FFFF; in_carry = 1'b1;
    @(posedge clk); #1;
    check({out_carry, out_result} === held, "R10", {out_carry, out_result}, held);
    check(out_valid === 1'b0, "R8", {32'd0, out_valid}, 33'd0);
    @(posedge clk); #1;
    check({out_carry, out_result} === held, "R10", {out_carry, out_result}, held);
  endtask

  task automatic t_reset_mid();
    apply(3'd3, 8'd1, 32'h0000_0003, 1'b0, "R5");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_operand = 32'hFFFF_FFFF; in_op = 3'd7; in_carry = 1'b1;
    @(posedge clk); #1;
    check(out_valid === 1'b0 && out_result === '0 && out_carry === 1'b0, "R9",
          {out_carry, out_result}, 33'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sweep(3'd0, "R2");
    t_sweep(3'd1, "R3");
    t_sweep(3'd2, "R4");
    t_sweep(3'd3, "R5");
    t_rrx();
    t_spare();
    t_hold();
    t_reset_mid();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule